// File: doc/BRIEF.md
# Multi-Mode Reloadable Timer Channel

This block is one 24-bit counter channel with a single timer pin. The pin is split into an input, an output and an output enable at the block edge. A small register port sets a 4-bit mode, an enable, a reload policy bit, a polarity bit, a direction bit and a GPIO output value. It also holds a load value and a compare value. The counter advances either on an internal tick supplied from outside or on rising edges of the pin. Its preload and reload behaviour is chosen by the mode group:

- **Compare group:** modes 0–3 and 9–10 preload on the first event and may reload on a compare match.
- **PWM:** mode 7 reloads whenever the counter overflows.
- **Measurement:** modes 4–5 may reload on a pin edge.
- **Other codes:** every remaining mode code simply counts ticks.

The control state machine has three named states:

- **ST_IDLE** is entered whenever the enable bit is 0.
- **ST_ARMED** is reached from ST_IDLE when enabled in a compare-group mode. It waits for the first event, and the transition **arm-to-run** loads the counter from the load register.
- **ST_RUN** is reached directly from ST_IDLE (transition **idle-to-run**) in all other modes. It stays there while enabled.

Clearing the enable bit takes any state back to ST_IDLE (transition **stop**). In ST_RUN, the counting and reload rule of the current mode group applies on each event.

The pin passes through a two-flop synchronizer. A polarity bit adjusts the synchronized level seen by the status bit, the edge detectors and the pin output. It does not adjust the raw synchronized level handed to an external prescaler. The polarity bit can only be changed while the channel is disabled or in mode 0.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0 and the pin output enable is 0.
- R2: In modes 0–3, 9 and 10, after the enable bit goes to 1 the first event (after one idle cycle) loads the counter with the load register value. Later events count up by one.
- R3: In modes 0–3, 9 and 10 with reload bit 1, an event while the counter equals the compare value reloads the counter from the load register.
- R4: With reload bit 0 in modes 0–3, 9 and 10, every event increments the counter by one, passing the compare value and wrapping to 0.
- R5: In mode 7, an event at counter value all-ones reloads the counter from the load register, whatever the reload bit is.
- R6: In mode 4 (rising) or mode 5 (falling) with reload and enable set, a polarity-adjusted pin edge reloads the counter three clocks after the pin changes. This takes priority over a tick in the same cycle. Otherwise each tick increments the counter.
- R7: In mode 3 the event is a rising edge of the polarity-adjusted pin. In every other mode the event is the internal tick input.
- R8: Control bit 9 reads the pin level XOR the polarity bit, two clocks after the pin changes.
- R9: In mode 0 the output enable equals the direction bit, and the pin output is the GPIO value bit XOR polarity. In modes 1, 2, 7, 9 and 10 the pin is driven. In modes 3, 4 and 5 it is not driven, and the direction bit is ignored in all nonzero modes.
- R10: In nonzero modes the pin output is the timer output XOR polarity. The timer output is 0 while disabled and toggles on each compare match or PWM overflow. The prescaler source output is the synchronized pin without inversion.
- R11: A write to the polarity bit takes effect only if, before that write, the channel was disabled or the mode was 0. Otherwise the bit keeps its value.
- R12: Register map:
  - Address 0 is control: bits 3:0 mode, 4 enable, 5 reload, 6 polarity, 7 direction, 8 GPIO value, 9 pin status (read-only). Bits above 9 read 0 and ignore writes.
  - Address 1 is load and address 2 is compare.
  - Address 3 reads the counter and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal count tick, one clock wide per event |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 24 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 24 | Register read data, combinational |
| pin_i | input | 1 | Timer pin input level |
| pin_o | output | 1 | Timer pin output level |
| pin_oe_o | output | 1 | Timer pin output enable |
| presc_src_o | output | 1 | Synchronized, non-inverted pin level for a prescaler |

## Verification
Two functions can land in the same cycle:

- **Measurement modes:** an edge-triggered reload and a tick increment coincide. The bench holds the tick high on every cycle while toggling the pin, so the detected edge always shares its cycle with a tick. It judges that the counter equals the load value exactly three clocks after the pin change, not the load value plus one.
- **Enable and polarity:** a control write can set the enable bit and change the polarity bit at once. Here the bench expects the polarity write to be accepted, because the decision rests on the state before the write. It then expects a later polarity write during operation to be discarded.

A behavioural model run on every clock compares the read data and all pin outputs throughout.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int MODE_W = 4;

    // register addresses
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LOAD = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;
    localparam logic [1:0] A_CNT  = 2'd3;

    // control word bit positions
    localparam int B_EN  = 4;
    localparam int B_RL  = 5;
    localparam int B_INV = 6;
    localparam int B_DIR = 7;
    localparam int B_GPO = 8;
    localparam int B_DIN = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        GRP_CMP  = 2'd0,
        GRP_PWM  = 2'd1,
        GRP_MEAS = 2'd2,
        GRP_FREE = 2'd3
    } tmr_grp_e;

    function automatic tmr_grp_e mode_group(input logic [MODE_W-1:0] m);
        tmr_grp_e g;
        unique case (m)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd9, 4'd10: g = GRP_CMP;
            4'd7:                                g = GRP_PWM;
            4'd4, 4'd5:                          g = GRP_MEAS;
            default:                             g = GRP_FREE;
        endcase
        return g;
    endfunction

    function automatic logic mode_drives_pin(input logic [MODE_W-1:0] m);
        return (m == 4'd1) || (m == 4'd2) || (m == 4'd7) ||
               (m == 4'd9) || (m == 4'd10);
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic sync,
    output logic prev
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], pin};
        end
    end

    assign sync = sh[STAGES-1];
    assign prev = sh[STAGES];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [1:0]        rd_addr,
    input  logic [CW-1:0]     cnt,
    input  logic              din,
    output logic [MODE_W-1:0] mode,
    output logic              en,
    output logic              rl,
    output logic              inv,
    output logic              dir,
    output logic              gpo,
    output logic [CW-1:0]     ld,
    output logic [CW-1:0]     cmp,
    output logic [CW-1:0]     rd_data
);
    logic          inv_open;
    logic [CW-1:0] ctrl_rd;

    // polarity may change only while stopped or in pure GPIO mode
    assign inv_open = !en || (mode == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
            en   <= 1'b0;
            rl   <= 1'b0;
            inv  <= 1'b0;
            dir  <= 1'b0;
            gpo  <= 1'b0;
            ld   <= '0;
            cmp  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    mode <= wr_data[MODE_W-1:0];
                    en   <= wr_data[B_EN];
                    rl   <= wr_data[B_RL];
                    dir  <= wr_data[B_DIR];
                    gpo  <= wr_data[B_GPO];
                    if (inv_open) inv <= wr_data[B_INV];
                end
                A_LOAD:  ld  <= wr_data;
                A_CMP:   cmp <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        ctrl_rd               = '0;
        ctrl_rd[MODE_W-1:0]   = mode;
        ctrl_rd[B_EN]         = en;
        ctrl_rd[B_RL]         = rl;
        ctrl_rd[B_INV]        = inv;
        ctrl_rd[B_DIR]        = dir;
        ctrl_rd[B_GPO]        = gpo;
        ctrl_rd[B_DIN]        = din;
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = ctrl_rd;
            A_LOAD:  rd_data = ld;
            A_CMP:   rd_data = cmp;
            default: rd_data = cnt;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              en,
    input  logic              rl,
    input  logic [CW-1:0]     ld,
    input  logic [CW-1:0]     cmp,
    input  logic              tick,
    input  logic              ev,
    input  logic              rise,
    input  logic              fall,
    output logic [CW-1:0]     cnt,
    output logic              tout,
    output tmr_state_e        st
);
    localparam logic [CW-1:0] CNT_MAX  = '1;
    localparam logic [MODE_W-1:0] M_RISE = MODE_W'(4);

    tmr_state_e st_nxt;
    tmr_grp_e   grp;
    logic       meas_edge;

    assign grp       = mode_group(mode);
    assign meas_edge = (mode == M_RISE) ? rise : fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        if (!en) begin
            st_nxt = ST_IDLE;                          // stop
        end else begin
            unique case (st)
                ST_IDLE:  st_nxt = (grp == GRP_CMP) ? ST_ARMED : ST_RUN;
                ST_ARMED: if (ev) st_nxt = ST_RUN;     // arm-to-run
                ST_RUN:   st_nxt = ST_RUN;
                default:  st_nxt = ST_IDLE;
            endcase
        end
    end

    // outputs: counter and timer output level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tout <= 1'b0;
        end else if (!en) begin
            tout <= 1'b0;
        end else begin
            unique case (st)
                ST_ARMED: if (ev) cnt <= ld;
                ST_RUN: begin
                    unique case (grp)
                        GRP_CMP: if (ev) begin
                            if (cnt == cmp) begin
                                tout <= ~tout;
                                cnt  <= rl ? ld : cnt + 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        GRP_PWM: if (ev) begin
                            if (cnt == CNT_MAX) begin
                                tout <= ~tout;
                                cnt  <= ld;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        GRP_MEAS: begin
                            if (rl && meas_edge) cnt <= ld;
                            else if (tick)       cnt <= cnt + 1'b1;
                        end
                        default: if (tick) cnt <= cnt + 1'b1;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW         = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_addr_i,
    input  logic [CW-1:0] wr_data_i,
    input  logic [1:0]    rd_addr_i,
    output logic [CW-1:0] rd_data_o,
    input  logic          pin_i,
    output logic          pin_o,
    output logic          pin_oe_o,
    output logic          presc_src_o
);
    localparam logic [MODE_W-1:0] M_EVCNT = MODE_W'(3);

    logic [MODE_W-1:0] mode_q;
    logic              en_q, rl_q, inv_q, dir_q, gpo_q;
    logic [CW-1:0]     ld_q, cmp_q, cnt_q;
    logic              pin_s, pin_p;
    logic              din, prv_adj, rise, fall, ev, tout;
    tmr_state_e        st_q;

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .pin (pin_i),
        .sync(pin_s),
        .prev(pin_p)
    );

    assign din     = pin_s ^ inv_q;
    assign prv_adj = pin_p ^ inv_q;
    assign rise    = din & ~prv_adj;
    assign fall    = ~din & prv_adj;
    assign ev      = (mode_q == M_EVCNT) ? rise : tick_i;

    tmr_regs #(.CW(CW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_i),
        .wr_addr(wr_addr_i),
        .wr_data(wr_data_i),
        .rd_addr(rd_addr_i),
        .cnt    (cnt_q),
        .din    (din),
        .mode   (mode_q),
        .en     (en_q),
        .rl     (rl_q),
        .inv    (inv_q),
        .dir    (dir_q),
        .gpo    (gpo_q),
        .ld     (ld_q),
        .cmp    (cmp_q),
        .rd_data(rd_data_o)
    );

    tmr_core #(.CW(CW)) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode_q),
        .en   (en_q),
        .rl   (rl_q),
        .ld   (ld_q),
        .cmp  (cmp_q),
        .tick (tick_i),
        .ev   (ev),
        .rise (rise),
        .fall (fall),
        .cnt  (cnt_q),
        .tout (tout),
        .st   (st_q)
    );

    // pin muxing: GPIO only when the mode field is zero
    always_comb begin
        if (mode_q == '0) begin
            pin_oe_o = dir_q;
            pin_o    = gpo_q ^ inv_q;
        end else begin
            pin_oe_o = mode_drives_pin(mode_q);
            pin_o    = tout ^ inv_q;
        end
    end

    assign presc_src_o = pin_s;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
#(
    parameter int CW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic              en,
    input logic              rl,
    input logic              inv,
    input logic              dir,
    input logic              ev,
    input logic              pin_oe,
    input logic [CW-1:0]     cnt,
    input logic [CW-1:0]     ld,
    input logic [CW-1:0]     cmp,
    input logic [1:0]        st
);
    logic in_cmp;
    assign in_cmp = (mode_group(mode) == GRP_CMP);

    // R2
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && en && ev) |=> (cnt == $past(ld)));

    // R3
    cmp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && en && in_cmp && rl && ev && cnt == cmp) |=> (cnt == $past(ld)));

    // R4
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && en && in_cmp && !rl && ev) |=> (cnt == CW'($past(cnt) + 1'b1)));

    // R5
    pwm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && en && mode == 4'd7 && ev && (&cnt)) |=> (cnt == $past(ld)));

    // R9
    gpio_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == '0) |-> (pin_oe == dir));

    // R9
    input_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd3 || mode == 4'd4 || mode == 4'd5) |-> !pin_oe);

    // R11
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(mode) != '0) |-> (inv == $past(inv)));
endmodule

bind tmr_channel tmr_channel_chk #(.CW(CW)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode_q),
    .en    (en_q),
    .rl    (rl_q),
    .inv   (inv_q),
    .dir   (dir_q),
    .ev    (ev),
    .pin_oe(pin_oe_o),
    .cnt   (cnt_q),
    .ld    (ld_q),
    .cmp   (cmp_q),
    .st    (st_q)
);

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [1:0]    rd_addr = 2'd3;
    logic [CW-1:0] wr_data = '0;
    logic          pin = 1'b0;
    wire  [CW-1:0] rd_data;
    wire           pin_o, pin_oe, presc;

    always #4 clk = ~clk;

    tmr_channel uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .pin_i      (pin),
        .pin_o      (pin_o),
        .pin_oe_o   (pin_oe),
        .presc_src_o(presc)
    );

    int    total = 0;
    int    bad = 0;
    string req = "R1";

    // behavioural reference
    int          m_mode, m_st;
    bit          m_en, m_rl, m_inv, m_dir, m_gpo, m_tout, s1, s2, s3;
    logic [CW-1:0] m_ld, m_cmp, m_cnt;

    function automatic logic [CW-1:0] m_read(input logic [1:0] a);
        logic [CW-1:0] v = '0;
        case (a)
            2'd0: begin
                v[3:0] = m_mode[3:0]; v[4] = m_en; v[5] = m_rl; v[6] = m_inv;
                v[7] = m_dir; v[8] = m_gpo; v[9] = s2 ^ m_inv;
            end
            2'd1: v = m_ld;
            2'd2: v = m_cmp;
            default: v = m_cnt;
        endcase
        return v;
    endfunction

    function automatic bit m_oe();
        if (m_mode == 0) return m_dir;
        return m_mode == 1 || m_mode == 2 || m_mode == 7 || m_mode == 9 || m_mode == 10;
    endfunction

    function automatic bit m_po();
        return ((m_mode == 0) ? m_gpo : m_tout) ^ m_inv;
    endfunction

    task automatic chk(input logic [CW-1:0] act, input logic [CW-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit adj = s2 ^ m_inv;
        bit prv = s3 ^ m_inv;
        bit rise = adj && !prv;
        bit fall = !adj && prv;
        bit ev = (m_mode == 3) ? rise : tick;
        bit cgrp = (m_mode <= 3) || m_mode == 9 || m_mode == 10;
        bit en_old = m_en;
        int mode_old = m_mode;
        if (!m_en) begin
            m_st = 0; m_tout = 0;
        end else if (m_st == 0) begin
            m_st = cgrp ? 1 : 2;
        end else if (m_st == 1) begin
            if (ev) begin m_cnt = m_ld; m_st = 2; end
        end else if (cgrp) begin
            if (ev) begin
                if (m_cnt == m_cmp) begin
                    m_tout = !m_tout;
                    m_cnt = m_rl ? m_ld : m_cnt + 1;
                end else m_cnt = m_cnt + 1;
            end
        end else if (m_mode == 7) begin
            if (ev) begin
                if (m_cnt == '1) begin m_tout = !m_tout; m_cnt = m_ld; end
                else m_cnt = m_cnt + 1;
            end
        end else if (m_mode == 4 || m_mode == 5) begin
            if (m_rl && ((m_mode == 4) ? rise : fall)) m_cnt = m_ld;
            else if (tick) m_cnt = m_cnt + 1;
        end else if (tick) m_cnt = m_cnt + 1;
        s3 = s2; s2 = s1; s1 = pin;
        if (wr_en) begin
            case (wr_addr)
                2'd0: begin
                    m_mode = int'(wr_data[3:0]); m_en = wr_data[4]; m_rl = wr_data[5];
                    m_dir = wr_data[7]; m_gpo = wr_data[8];
                    if (!en_old || mode_old == 0) m_inv = wr_data[6];
                end
                2'd1: m_ld = wr_data;
                2'd2: m_cmp = wr_data;
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_st = 0; m_en = 0; m_rl = 0; m_inv = 0; m_dir = 0; m_gpo = 0;
            m_tout = 0; s1 = 0; s2 = 0; s3 = 0; m_ld = '0; m_cmp = '0; m_cnt = '0;
        end else begin
            model_step();
            #2;
            chk(rd_data, m_read(rd_addr), {req, " model read"});
            chk(CW'(pin_oe), CW'(m_oe()), {req, " model oe"});
            chk(CW'(pin_o), CW'(m_po()), {req, " model pin"});
            chk(CW'(presc), CW'(s2), {req, " model presc"});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CW-1:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [CW-1:0] v;
        bit flag, seen;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(2'd0, v); chk(v, '0, "R1 ctrl");
        rd(2'd3, v); chk(v, '0, "R1 cnt");
        chk(CW'(pin_oe), '0, "R1 oe");

        // R8 pin status latency and polarity, R10 prescaler not inverted
        req = "R8";
        @(negedge clk) pin = 1'b1;
        cyc(1); rd(2'd0, v); chk(CW'(v[9]), '0, "R8 din after one clock");
        cyc(1); rd(2'd0, v); chk(CW'(v[9]), CW'(1), "R8 din after two clocks");
        wr(2'd0, 24'h040);
        cyc(1); rd(2'd0, v); chk(CW'(v[9]), '0, "R8 din inverted");
        chk(CW'(presc), CW'(1), "R10 presc not inverted");
        @(negedge clk) pin = 1'b0;
        cyc(3);

        // R9 GPIO output with polarity
        req = "R9";
        wr(2'd0, 24'h180);
        chk(CW'(pin_oe), CW'(1), "R9 gpio oe");
        chk(CW'(pin_o), CW'(1), "R9 gpio out");
        wr(2'd0, 24'h1C0);
        chk(CW'(pin_o), '0, "R9 gpio out inverted");
        wr(2'd0, 24'h083);
        chk(CW'(pin_oe), '0, "R9 dir ignored in mode 3");
        wr(2'd0, 24'h009);
        chk(CW'(pin_oe), CW'(1), "R9 watchdog mode drives");
        wr(2'd0, 24'h000);

        // R2 preload on first event
        req = "R2";
        wr(2'd1, 24'd5); wr(2'd2, 24'd8);
        wr(2'd0, 24'h031);
        cyc(3);
        rd(2'd3, v); chk(v, '0, "R2 no load before event");
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        rd(2'd3, v); chk(v, 24'd5, "R2 preload value");

        // R3 compare reload, tick every cycle
        req = "R3";
        @(negedge clk) tick = 1'b1;
        flag = 0; seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); rd(2'd3, v);
            if (v > 24'd8) flag = 1;
            if (v == 24'd8) seen = 1;
        end
        chk(CW'(flag), '0, "R3 never passes compare");
        chk(CW'(seen), CW'(1), "R3 reaches compare");

        // R10 polarity on timer output; R11 gated polarity write
        req = "R11";
        wr(2'd0, 24'h071);
        rd(2'd0, v); chk(CW'(v[6]), '0, "R11 inv write discarded while running");
        wr(2'd0, 24'h000);
        wr(2'd0, 24'h040);
        rd(2'd0, v); chk(CW'(v[6]), CW'(1), "R11 inv write accepted while stopped");
        req = "R10";
        wr(2'd0, 24'h051);
        chk(CW'(pin_o), CW'(1), "R10 timer output inverted at start");
        cyc(12);

        // R4 free running
        req = "R4";
        wr(2'd0, 24'h040);
        wr(2'd0, 24'h051);
        cyc(14);
        rd(2'd3, v); chk(CW'(v > 24'd8), CW'(1), "R4 passes compare");

        // R5 PWM overflow reload
        req = "R5";
        tick = 1'b0;
        wr(2'd0, 24'h040);
        wr(2'd1, 24'hFFFFFC);
        wr(2'd0, 24'h051);
        cyc(2);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        wr(2'd0, 24'h057);
        @(negedge clk) tick = 1'b1;
        flag = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); rd(2'd3, v);
            if (v < 24'hFFFFFC) flag = 1;
        end
        chk(CW'(flag), '0, "R5 reload at overflow");

        // R7 external event counting in mode 3, polarity off
        req = "R7";
        tick = 1'b0;
        wr(2'd0, 24'h000);
        wr(2'd0, 24'h000);
        wr(2'd1, 24'd0);
        wr(2'd0, 24'h013);
        cyc(2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) pin = 1'b1;
            cyc(3);
            @(negedge clk) pin = 1'b0;
            cyc(3);
        end
        cyc(3);
        rd(2'd3, v); chk(v, 24'd3, "R7 pin edge count");

        // R6 measurement reload with simultaneous tick
        req = "R6";
        wr(2'd1, 24'd100);
        wr(2'd0, 24'h034);
        tick = 1'b1;
        cyc(6);
        @(negedge clk) pin = 1'b1;
        cyc(2);
        rd(2'd3, v); chk(CW'(v == 24'd100), '0, "R6 no reload before edge seen");
        cyc(1);
        rd(2'd3, v); chk(v, 24'd100, "R6 rising edge reload over tick");
        wr(2'd0, 24'h035);
        cyc(4);
        @(negedge clk) pin = 1'b0;
        cyc(3);
        rd(2'd3, v); chk(v, 24'd100, "R6 falling edge reload");
        wr(2'd0, 24'h014);
        cyc(3);
        @(negedge clk) pin = 1'b1;
        cyc(5);
        rd(2'd3, v); chk(CW'(v > 24'd104), CW'(1), "R6 no reload without reload bit");
        tick = 1'b0;

        // R12 reserved bits and read-only counter
        req = "R12";
        wr(2'd0, 24'h000);
        wr(2'd0, 24'hFFFFFF);
        rd(2'd0, v); chk(v & 24'hFFFDFF, 24'h0001FF, "R12 reserved bits read zero");
        rd(2'd3, v);
        wr(2'd3, 24'h123456);
        begin
            logic [CW-1:0] w;
            rd(2'd3, w);
            chk(CW'(w == 24'h123456), '0, "R12 counter write ignored");
        end
        wr(2'd0, 24'h000);
        rd(2'd0, v); chk(CW'(v[6]), CW'(1), "R11 inv kept when mode nonzero and enabled");
        wr(2'd0, 24'h000);
        rd(2'd0, v); chk(CW'(v[6]), '0, "R11 inv cleared once stopped");
        cyc(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule